// File: doc/BRIEF.md
# Asymmetric Block Protection Map

This block sits in front of a 512 KB non-volatile array cut into eleven erase blocks of unequal size. It turns a byte address into a block number for one of two mirrored layouts. One layout has the small blocks at the top of the space and the other has them at the bottom; the parameter `BOTTOM_BOOT` selects which. It keeps one protection flag per block. Each program or erase request gets a one-cycle grant or deny pulse, based on that flag and on a temporary-unprotect level.

Setting and clearing flags is slow. Protecting one block takes `PROT_CYC` cycles and clearing every flag takes `UNPROT_CYC` cycles. While either sequence runs, the block reports busy and ignores further commands. The clear-all command is accepted only when every block is already protected. Otherwise it gives a one-cycle error pulse and changes nothing. A separate query address reads back the stored flag of any block as a status byte.

Top module: `blk_protect_map`

## Requirements
- R1: With `BOTTOM_BOOT`=0, blocks are numbered 0-10 in rising address order: 00000h-6FFFFh are blocks 0-6 in 64 KB steps, 70000h-77FFFh is block 7, 78000h-79FFFh is block 8, 7A000h-7BFFFh is block 9 and 7C000h-7FFFFh is block 10. `qry_blk_o` shows the number for `qry_addr_i` in the same cycle.
- R2: With `BOTTOM_BOOT`=1, 00000h-03FFFh is block 0, 04000h-05FFFh is block 1, 06000h-07FFFh is block 2, 08000h-0FFFFh is block 3, and 10000h-7FFFFh are blocks 4-10 in 64 KB steps.
- R3: After reset every flag is clear, `qry_data_o` reads 00h, and `busy_o`, `err_o`, `grant_o` and `deny_o` are 0.
- R4: A `req_i` sampled at a clock edge gives exactly one of `grant_o` or `deny_o` high for the single cycle after that edge. `deny_o` is given when the addressed block is protected and `temp_unprot_i` is low; otherwise `grant_o` is given.
- R5: While `temp_unprot_i` is high, requests to protected blocks are granted and the stored flags are not changed. Once it is low again, those same blocks are denied.
- R6: A `prot_req_i` accepted at edge E sets only the flag of the block at `addr_i`, at edge E+`PROT_CYC`. `busy_o` is high from E until then, and the query keeps showing the old state until then.
- R7: An `unprot_all_i` accepted at edge E while all eleven flags are set clears all flags at edge E+`UNPROT_CYC`. `busy_o` is high from E until then.
- R8: An `unprot_all_i` sampled while idle with any flag clear raises `err_o` for the one cycle after that edge. It leaves all flags unchanged and starts no busy period.
- R9: Commands sampled while `busy_o` is high are ignored. If `prot_req_i` and `unprot_all_i` are sampled together while idle, the protect command is taken and the clear-all is dropped without error.
- R10: `qry_data_o` is 01h when the stored flag of the queried block is set and 00h when it is clear, whatever the level of `temp_unprot_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 19 | Byte address for requests and protect commands |
| req_i | input | 1 | Program/erase request strobe |
| prot_req_i | input | 1 | Protect the block at `addr_i` |
| unprot_all_i | input | 1 | Clear every protection flag |
| temp_unprot_i | input | 1 | Level: treat all blocks as unprotected |
| qry_addr_i | input | 19 | Byte address for the status query |
| qry_blk_o | output | 4 | Block number of `qry_addr_i` |
| qry_data_o | output | 8 | 01h protected, 00h unprotected |
| grant_o | output | 1 | Request allowed, one-cycle pulse |
| deny_o | output | 1 | Request refused, one-cycle pulse |
| busy_o | output | 1 | Protect or clear-all sequence running |
| err_o | output | 1 | Clear-all refused, one-cycle pulse |

## Verification
The assertions take two things for granted. First, only a finished sequence changes a flag, and only reset clears flags between sequences. Second, the delay checks count busy cycles from the moment `busy_o` rises. Both hold only if the stimulus keeps reset high while a sequence runs. The bench keeps it high and never pulses reset mid-sequence. It applies requests and commands for one cycle each, away from the clock edge. It waits for a running sequence to finish before it checks the flag that the sequence changes.

// File: rtl/bpm_pkg.sv
package bpm_pkg;
  localparam int NUM_BLK = 11;
  localparam int BLK_W   = $clog2(NUM_BLK);
  localparam int ADDR_W  = 19;
  localparam int SEG_LSB = 16;  // 64 KB granule

  typedef logic [BLK_W-1:0] blk_idx_t;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_PROT,
    SEQ_UNPROT
  } seq_state_e;

  localparam logic [7:0] STAT_PROT = 8'h01;
  localparam logic [7:0] STAT_OPEN = 8'h00;
endpackage

// File: rtl/bpm_addr_decode.sv
module bpm_addr_decode
  import bpm_pkg::*;
#(
  parameter bit BOTTOM_BOOT = 1'b0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output blk_idx_t          blk_o
);
  localparam int SEG_W     = ADDR_W - SEG_LSB;
  localparam int NUM_LARGE = (1 << SEG_W) - 1;
  localparam int SMALL_CNT = NUM_BLK - NUM_LARGE;

  logic [SEG_W-1:0] seg;
  logic b_hi, b_mid, b_lo;

  assign seg   = addr_i[ADDR_W-1:SEG_LSB];
  assign b_hi  = addr_i[SEG_LSB-1];
  assign b_mid = addr_i[SEG_LSB-2];
  assign b_lo  = addr_i[SEG_LSB-3];

  generate
    if (BOTTOM_BOOT) begin : g_bottom
      always_comb begin
        if (seg != '0)  blk_o = BLK_W'(seg) + BLK_W'(SMALL_CNT - 1);
        else if (b_hi)  blk_o = BLK_W'(SMALL_CNT - 1);
        else if (!b_mid) blk_o = BLK_W'(0);
        else if (b_lo)  blk_o = BLK_W'(2);
        else            blk_o = BLK_W'(1);
      end
    end else begin : g_top
      always_comb begin
        if (seg != '1)  blk_o = BLK_W'(seg);
        else if (!b_hi) blk_o = BLK_W'(NUM_LARGE);
        else if (b_mid) blk_o = BLK_W'(NUM_BLK - 1);
        else if (b_lo)  blk_o = BLK_W'(NUM_BLK - 2);
        else            blk_o = BLK_W'(NUM_BLK - 3);
      end
    end
  endgenerate
endmodule

// File: rtl/bpm_flag_bank.sv
module bpm_flag_bank
  import bpm_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_i,
  input  blk_idx_t           set_blk_i,
  input  logic               clr_all_i,
  output logic [NUM_BLK-1:0] flags_o
);
  for (genvar g = 0; g < NUM_BLK; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 flags_o[g] <= 1'b0;
      else if (clr_all_i)                          flags_o[g] <= 1'b0;
      else if (set_i && set_blk_i == BLK_W'(g))    flags_o[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/bpm_prot_seq.sv
module bpm_prot_seq
  import bpm_pkg::*;
#(
  parameter int PROT_CYC   = 100,
  parameter int UNPROT_CYC = 10000
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     prot_req_i,
  input  logic     unprot_all_i,
  input  blk_idx_t blk_i,
  input  logic     all_prot_i,
  output logic     busy_o,
  output logic     set_o,
  output blk_idx_t set_blk_o,
  output logic     clr_all_o,
  output logic     err_o
);
  localparam int MAX_CYC = (PROT_CYC > UNPROT_CYC) ? PROT_CYC : UNPROT_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  blk_idx_t         tgt_q;
  logic             err_q;
  logic             last;

  assign last = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      tgt_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (state_q)
        SEQ_IDLE: begin
          if (prot_req_i) begin
            state_q <= SEQ_PROT;
            cnt_q   <= CNT_W'(PROT_CYC - 1);
            tgt_q   <= blk_i;
          end else if (unprot_all_i) begin
            if (all_prot_i) begin
              state_q <= SEQ_UNPROT;
              cnt_q   <= CNT_W'(UNPROT_CYC - 1);
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        SEQ_PROT, SEQ_UNPROT: begin
          if (last) state_q <= SEQ_IDLE;
          else      cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != SEQ_IDLE);
  assign set_o     = (state_q == SEQ_PROT) && last;
  assign clr_all_o = (state_q == SEQ_UNPROT) && last;
  assign set_blk_o = tgt_q;
  assign err_o     = err_q;
endmodule

// File: rtl/blk_protect_map.sv
module blk_protect_map
  import bpm_pkg::*;
#(
  parameter bit BOTTOM_BOOT = 1'b0,
  parameter int PROT_CYC    = 100,
  parameter int UNPROT_CYC  = 10000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              req_i,
  input  logic              prot_req_i,
  input  logic              unprot_all_i,
  input  logic              temp_unprot_i,
  input  logic [ADDR_W-1:0] qry_addr_i,
  output logic [BLK_W-1:0]  qry_blk_o,
  output logic [7:0]        qry_data_o,
  output logic              grant_o,
  output logic              deny_o,
  output logic              busy_o,
  output logic              err_o
);
  blk_idx_t           req_blk, qry_blk, set_blk;
  logic [NUM_BLK-1:0] flags_q;
  logic               set_en, clr_all;
  logic               req_flag, qry_flag, eff_prot;
  logic               grant_q, deny_q;

  bpm_addr_decode #(.BOTTOM_BOOT(BOTTOM_BOOT)) u_dec_req (
    .addr_i(addr_i), .blk_o(req_blk)
  );

  bpm_addr_decode #(.BOTTOM_BOOT(BOTTOM_BOOT)) u_dec_qry (
    .addr_i(qry_addr_i), .blk_o(qry_blk)
  );

  bpm_prot_seq #(.PROT_CYC(PROT_CYC), .UNPROT_CYC(UNPROT_CYC)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .prot_req_i  (prot_req_i),
    .unprot_all_i(unprot_all_i),
    .blk_i       (req_blk),
    .all_prot_i  (&flags_q),
    .busy_o      (busy_o),
    .set_o       (set_en),
    .set_blk_o   (set_blk),
    .clr_all_o   (clr_all),
    .err_o       (err_o)
  );

  bpm_flag_bank u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_en),
    .set_blk_i(set_blk),
    .clr_all_i(clr_all),
    .flags_o  (flags_q)
  );

  always_comb begin
    req_flag = 1'b0;
    qry_flag = 1'b0;
    for (int i = 0; i < NUM_BLK; i++) begin
      if (req_blk == BLK_W'(i)) req_flag = flags_q[i];
      if (qry_blk == BLK_W'(i)) qry_flag = flags_q[i];
    end
  end

  // override never touches stored flags, so release restores them
  assign eff_prot = req_flag & ~temp_unprot_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q <= 1'b0;
      deny_q  <= 1'b0;
    end else begin
      grant_q <= req_i & ~eff_prot;
      deny_q  <= req_i & eff_prot;
    end
  end

  assign grant_o    = grant_q;
  assign deny_o     = deny_q;
  assign qry_blk_o  = qry_blk;
  assign qry_data_o = qry_flag ? STAT_PROT : STAT_OPEN;
endmodule

// File: rtl/bpm_checker.sv
module bpm_checker
  import bpm_pkg::*;
#(
  parameter int PROT_CYC   = 100,
  parameter int UNPROT_CYC = 10000
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_BLK-1:0] flags,
  input logic               busy_o,
  input logic               err_o,
  input logic               grant_o,
  input logic               deny_o,
  input logic               req_i,
  input logic               temp_unprot_i,
  input logic [7:0]         qry_data_o
);
  logic [31:0] run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_cnt <= '0;
    else if (busy_o) run_cnt <= run_cnt + 1'b1;
    else             run_cnt <= '0;
  end

  AST_GRANT_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o || deny_o) |-> $past(req_i)); // R4

  AST_TEMP_NO_DENY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deny_o |-> !$past(temp_unprot_i)); // R5

  AST_PROT_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(flags) > $countones($past(flags))) |-> (run_cnt >= 32'(PROT_CYC))); // R6

  AST_SINGLE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(flags) > $countones($past(flags)))
      |-> ($countones(flags) == $countones($past(flags)) + 1)); // R6

  AST_UNPROT_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(flags) < $countones($past(flags)))
      |-> (run_cnt >= 32'(UNPROT_CYC) && flags == '0)); // R7

  AST_UNPROT_NEEDS_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(flags) < $countones($past(flags))) |-> (&$past(flags))); // R7

  AST_ERR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (flags == $past(flags) && !busy_o)); // R8

  AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o); // R8

  AST_QRY_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qry_data_o[7:1] == 7'd0); // R10
endmodule

bind blk_protect_map bpm_checker #(.PROT_CYC(PROT_CYC), .UNPROT_CYC(UNPROT_CYC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .flags        (flags_q),
  .busy_o       (busy_o),
  .err_o        (err_o),
  .grant_o      (grant_o),
  .deny_o       (deny_o),
  .req_i        (req_i),
  .temp_unprot_i(temp_unprot_i),
  .qry_data_o   (qry_data_o)
);

// File: tb/tb_blk_protect_map.sv
module tb_blk_protect_map;
  localparam int CLK_P   = 10;
  localparam int P_CYC   = 100;
  localparam int U_CYC   = 10000;
  localparam int WDOG    = 200000;
  localparam int NVEC    = 20;

  // {address, top-boot block, bottom-boot block}
  localparam logic [26:0] MAP_VEC [NVEC] = '{
    {19'h00000, 4'd0,  4'd0},  {19'h03FFF, 4'd0,  4'd0},
    {19'h04000, 4'd0,  4'd1},  {19'h05FFF, 4'd0,  4'd1},
    {19'h06000, 4'd0,  4'd2},  {19'h07FFF, 4'd0,  4'd2},
    {19'h08000, 4'd0,  4'd3},  {19'h0FFFF, 4'd0,  4'd3},
    {19'h10000, 4'd1,  4'd4},  {19'h3ABCD, 4'd3,  4'd6},
    {19'h6FFFF, 4'd6,  4'd9},  {19'h70000, 4'd7,  4'd10},
    {19'h77FFF, 4'd7,  4'd10}, {19'h78000, 4'd8,  4'd10},
    {19'h79FFF, 4'd8,  4'd10}, {19'h7A000, 4'd9,  4'd10},
    {19'h7BFFF, 4'd9,  4'd10}, {19'h7C000, 4'd10, 4'd10},
    {19'h7E123, 4'd10, 4'd10}, {19'h7FFFF, 4'd10, 4'd10}
  };

  localparam logic [18:0] BLK_BASE [11] = '{
    19'h00000, 19'h10000, 19'h20000, 19'h30000, 19'h40000, 19'h50000,
    19'h60000, 19'h70000, 19'h78000, 19'h7A000, 19'h7C000
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [18:0] addr_i = '0, qry_addr_i = '0;
  logic        req_i = 1'b0, prot_req_i = 1'b0, unprot_all_i = 1'b0, temp_unprot_i = 1'b0;
  logic [3:0]  qry_blk_o, qry_blk_b;
  logic [7:0]  qry_data_o, qry_data_b;
  logic        grant_o, deny_o, busy_o, err_o;
  logic        grant_b, deny_b, busy_b, err_b;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  blk_protect_map #(.BOTTOM_BOOT(1'b0), .PROT_CYC(P_CYC), .UNPROT_CYC(U_CYC)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .req_i(req_i),
    .prot_req_i(prot_req_i), .unprot_all_i(unprot_all_i), .temp_unprot_i(temp_unprot_i),
    .qry_addr_i(qry_addr_i), .qry_blk_o(qry_blk_o), .qry_data_o(qry_data_o),
    .grant_o(grant_o), .deny_o(deny_o), .busy_o(busy_o), .err_o(err_o)
  );

  blk_protect_map #(.BOTTOM_BOOT(1'b1), .PROT_CYC(P_CYC), .UNPROT_CYC(U_CYC)) dut_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(19'h0), .req_i(1'b0),
    .prot_req_i(1'b0), .unprot_all_i(1'b0), .temp_unprot_i(1'b0),
    .qry_addr_i(qry_addr_i), .qry_blk_o(qry_blk_b), .qry_data_o(qry_data_b),
    .grant_o(grant_b), .deny_o(deny_b), .busy_o(busy_b), .err_o(err_b)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic query(input logic [18:0] a);
    qry_addr_i = a;
    #1;
  endtask

  task automatic request(input logic [18:0] a);
    addr_i = a; req_i = 1'b1;
    step();
    req_i = 1'b0;
  endtask

  task automatic protect_quiet(input logic [18:0] a);
    addr_i = a; prot_req_i = 1'b1;
    step();
    prot_req_i = 1'b0;
    step(P_CYC);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > WDOG && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WDOG);
      summary();
      $finish;
    end
  end

  initial begin
    step(3);
    rst_ni = 1'b1;
    step();

    // R3 reset state
    query(19'h7C000);
    chk("R3 qry", qry_data_o, 8'h00);
    chk("R3 busy", busy_o, 0);
    chk("R3 err", err_o, 0);
    chk("R3 grant/deny", {grant_o, deny_o}, 0);
    query(19'h00000);
    chk("R3 qry b", qry_data_b, 8'h00);

    // R1 / R2 map walk
    for (int i = 0; i < NVEC; i++) begin
      query(MAP_VEC[i][26:8]);
      chk("R1 top map", qry_blk_o, MAP_VEC[i][7:4]);
      chk("R2 bottom map", qry_blk_b, MAP_VEC[i][3:0]);
    end

    // R4 grant on unprotected block, single pulse
    request(19'h50000);
    chk("R4 grant", {grant_o, deny_o}, 2'b10);
    step();
    chk("R4 pulse end", {grant_o, deny_o}, 2'b00);

    // R6 protect timing on block 10
    addr_i = 19'h7E000; prot_req_i = 1'b1;
    step();
    prot_req_i = 1'b0;
    chk("R6 busy rise", busy_o, 1);
    step(P_CYC - 1);
    query(19'h7C000);
    chk("R6 not early", qry_data_o, 8'h00);
    chk("R6 still busy", busy_o, 1);
    step();
    chk("R6 set", qry_data_o, 8'h01);
    chk("R6 busy fall", busy_o, 0);
    query(19'h7A000);
    chk("R10 neighbour open", qry_data_o, 8'h00);

    // R4 deny on protected block
    request(19'h7FFFF);
    chk("R4 deny", {grant_o, deny_o}, 2'b01);

    // R8 refused clear-all
    unprot_all_i = 1'b1;
    step();
    unprot_all_i = 1'b0;
    chk("R8 err pulse", err_o, 1);
    chk("R8 no busy", busy_o, 0);
    step();
    chk("R8 err end", err_o, 0);
    query(19'h7C000);
    chk("R8 flag kept", qry_data_o, 8'h01);

    // R5 temporary override
    temp_unprot_i = 1'b1;
    request(19'h7C000);
    chk("R5 grant under override", {grant_o, deny_o}, 2'b10);
    chk("R10 qry under override", qry_data_o, 8'h01);
    temp_unprot_i = 1'b0;
    request(19'h7C000);
    chk("R5 deny after release", {grant_o, deny_o}, 2'b01);

    // R9 commands ignored while busy
    addr_i = 19'h00000; prot_req_i = 1'b1;
    step();
    addr_i = 19'h10000; unprot_all_i = 1'b1;
    step();
    prot_req_i = 1'b0; unprot_all_i = 1'b0;
    chk("R9 no err while busy", err_o, 0);
    step();
    chk("R9 no err later", err_o, 0);
    step(P_CYC - 3);
    chk("R9 busy", busy_o, 1);
    step();
    chk("R9 done", busy_o, 0);
    query(19'h00000);
    chk("R9 first protected", qry_data_o, 8'h01);
    query(19'h10000);
    chk("R9 second ignored", qry_data_o, 8'h00);

    // R9 simultaneous: protect wins
    addr_i = 19'h20000; prot_req_i = 1'b1; unprot_all_i = 1'b1;
    step();
    prot_req_i = 1'b0; unprot_all_i = 1'b0;
    chk("R9 protect taken", busy_o, 1);
    chk("R9 no err simul", err_o, 0);
    step(P_CYC);
    query(19'h20000);
    chk("R9 simul flag", qry_data_o, 8'h01);

    // R7 full clear-all
    for (int b = 1; b < 10; b++)
      if (b != 2) protect_quiet(BLK_BASE[b]);
    for (int b = 0; b < 11; b++) begin
      query(BLK_BASE[b]);
      chk("R7 all set", qry_data_o, 8'h01);
    end
    unprot_all_i = 1'b1;
    step();
    unprot_all_i = 1'b0;
    chk("R7 busy", busy_o, 1);
    chk("R7 no err", err_o, 0);
    step(U_CYC - 1);
    query(19'h3A000);
    chk("R7 not early", qry_data_o, 8'h01);
    step();
    chk("R7 busy fall", busy_o, 0);
    for (int b = 0; b < 11; b++) begin
      query(BLK_BASE[b]);
      chk("R7 cleared", qry_data_o, 8'h00);
    end
    request(19'h7C000);
    chk("R7 grant after clear", {grant_o, deny_o}, 2'b10);

    // R3 reset clears flags
    protect_quiet(19'h40000);
    rst_ni = 1'b0;
    #2;
    query(19'h40000);
    chk("R3 reset clears", qry_data_o, 8'h00);
    step();
    rst_ni = 1'b1;
    step();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule